// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block hands the system clock over from a slow secondary oscillator to a faster primary oscillator. It also hands it back. Software drives a single select bit. When that bit is set, the block enables the primary source and runs a warm-up wait. The wait is counted in primary-clock cycles and its length depends on the configured primary mode.

In crystal mode the wait is an oscillator start-up count. When the PLL is on, a separate PLL lock count follows it. In external-clock mode the start-up count is skipped: only the PLL lock count applies when the PLL is on, and no wait applies when it is off. The system clock keeps running from the secondary oscillator for the whole wait, so execution never stops.

At the end of the wait, a glitch-free multiplexer changes the source. Each source's gate closes on that clock's falling edge, and each gate only opens after the other gate is seen closed through a two-stage synchroniser. A status bit and a one-cycle done pulse, both in the secondary domain, report the change only after it has happened.

Top module: `clk_switch_seq`

## Requirements
- R1: While `rst_n` is low and right after reset, `sys_clk` follows `clk_sec`, and `pri_ready`, `on_primary`, `switch_done` and `pri_osc_en` are all 0.
- R2: `pri_osc_en` is `sel_pri` registered on the rising edge of `clk_sec`.
- R3: Crystal mode (`mode_ext`=0) with `pll_on`=0: `sel_pri` set just after a `clk_pri` rising edge makes `pri_ready` go high after exactly 3+OST_CYCLES `clk_pri` rising edges. The 3 is two synchroniser stages plus the idle-exit edge. OST_CYCLES defaults to 1024.
- R4: Crystal mode with `pll_on`=1: `pri_ready` goes high after 3+OST_CYCLES+PLL cycles, because the PLL count follows the start-up count.
- R5: External-clock mode (`mode_ext`=1) with `pll_on`=1: `pri_ready` goes high after 3+PLL cycles, with no start-up count.
- R6: External-clock mode with `pll_on`=0: `pri_ready` goes high after 3 cycles.
- R7: PLL equals PRI_HZ/1000000 multiplied by PLL_LOCK_US. The defaults give a 2 ms lock time.
- R8: The two source gates are never open together. `sys_clk` follows `clk_sec` until the changeover and follows `clk_pri` after it.
- R9: `on_primary` rises only after `pri_ready` and after the primary gate has opened. `switch_done` pulses for exactly one `clk_sec` cycle per changeover.
- R10: Clearing `sel_pri` before the changeover aborts the wait. The count resets, `sys_clk` stays on `clk_sec`, and a new request gets the full wait again.
- R11: Clearing `sel_pri` after the changeover returns `sys_clk` to `clk_sec` and clears `on_primary`, without a `switch_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sec | input | 1 | Secondary (slow) oscillator clock |
| clk_pri | input | 1 | Primary oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pri | input | 1 | Software select bit: 1 requests the primary source |
| mode_ext | input | 1 | Primary mode: 0 crystal, 1 external clock (change only while idle) |
| pll_on | input | 1 | 1 inserts the PLL lock count (change only while idle) |
| sys_clk | output | 1 | Glitch-free muxed system clock |
| pri_osc_en | output | 1 | Enable for the primary oscillator path |
| pri_ready | output | 1 | Warm-up wait complete (primary domain) |
| on_primary | output | 1 | Status: primary currently drives `sys_clk` (secondary domain) |
| switch_done | output | 1 | One-cycle pulse when the changeover to primary completes |

## Verification
The bench sets OST_CYCLES to 32, PRI_HZ to 2 MHz and PLL_LOCK_US to 12, so the PLL count is 24 cycles. With these values all four mode combinations, an abort and a switch-back each finish in a few hundred primary cycles. That lets every wait length be measured edge by edge. The two clocks run at 10 ns and 34 ns, which are not integer multiples of each other, so the handshake crosses unaligned edges in both directions.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OSC   = 2'd1,
    WS_PLL   = 2'd2,
    WS_READY = 2'd3
  } wait_st_e;

  // Lock time in primary cycles, from frequency in Hz and time in microseconds.
  function automatic int unsigned pll_cycles(int unsigned hz, int unsigned us);
    return (hz / 1_000_000) * us;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= RST_VAL;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clksw_wait_seq.sv
module clksw_wait_seq
  import clksw_pkg::*;
#(
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned PLL_CYCLES = 16000
) (
  input  logic clk_pri,
  input  logic rst_n,
  input  logic req_s,
  input  logic mode_ext,
  input  logic pll_on,
  output logic ready
);
  localparam int unsigned MAXC  = max2(OST_CYCLES, PLL_CYCLES);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] OST_LAST = CNT_W'(OST_CYCLES - 1);
  localparam logic [CNT_W-1:0] PLL_LAST = CNT_W'(PLL_CYCLES - 1);

  wait_st_e         state, state_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (!req_s) begin
      state_nx = WS_IDLE;
      cnt_nx   = '0;
    end else begin
      unique case (state)
        WS_IDLE: begin
          cnt_nx = '0;
          if (!mode_ext)   state_nx = WS_OSC;
          else if (pll_on) state_nx = WS_PLL;
          else             state_nx = WS_READY;
        end
        WS_OSC: begin
          if (cnt == OST_LAST) begin
            cnt_nx   = '0;
            state_nx = pll_on ? WS_PLL : WS_READY;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        WS_PLL: begin
          if (cnt == PLL_LAST) begin
            cnt_nx   = '0;
            state_nx = WS_READY;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
        WS_READY: cnt_nx = '0;
        default:  state_nx = WS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_pri or negedge rst_n) begin
    if (!rst_n) begin
      state <= WS_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  assign ready = (state == WS_READY);

  // R10: a dropped request sends the sequencer back to idle at the next edge
  p_abort_idle_r10: assert property (@(posedge clk_pri) disable iff (!rst_n)
    !req_s |=> (state == WS_IDLE && cnt == '0));
  // R5: external-clock mode never enters the start-up count
  p_ext_skips_ost_r5: assert property (@(posedge clk_pri) disable iff (!rst_n)
    (state == WS_IDLE && req_s && mode_ext) |=> (state != WS_OSC));
  // R7: the lock count stays inside its window
  p_pll_bound_r7: assert property (@(posedge clk_pri) disable iff (!rst_n)
    (state == WS_PLL) |-> (32'(cnt) < PLL_CYCLES));
  // R3: the start-up count stays inside its window
  p_ost_bound_r3: assert property (@(posedge clk_pri) disable iff (!rst_n)
    (state == WS_OSC) |-> (32'(cnt) < OST_CYCLES));
endmodule

// File: rtl/clksw_gmux.sv
module clksw_gmux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_pri,
  input  logic clk_sec,
  input  logic rst_n,
  input  logic go_pri,
  output logic sys_clk,
  output logic gate_pri,
  output logic gate_sec
);
  logic want_pri, want_sec;
  logic want_pri_s, want_sec_s;

  assign want_pri = go_pri & ~gate_sec;
  assign want_sec = ~go_pri & ~gate_pri;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pri (
    .clk(clk_pri), .rst_n(rst_n), .d(want_pri), .q(want_pri_s));

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sec (
    .clk(clk_sec), .rst_n(rst_n), .d(want_sec), .q(want_sec_s));

  // Gates change only while their own clock is low.
  always_ff @(negedge clk_pri or negedge rst_n) begin
    if (!rst_n) gate_pri <= 1'b0;
    else        gate_pri <= want_pri_s;
  end

  always_ff @(negedge clk_sec or negedge rst_n) begin
    if (!rst_n) gate_sec <= 1'b1;
    else        gate_sec <= want_sec_s;
  end

  assign sys_clk = (clk_pri & gate_pri) | (clk_sec & gate_sec);

  // R8: the two gates are never open together
  p_one_gate_pri_r8: assert property (@(posedge clk_pri) disable iff (!rst_n)
    !(gate_pri && gate_sec));
  p_one_gate_sec_r8: assert property (@(posedge clk_sec) disable iff (!rst_n)
    !(gate_pri && gate_sec));
  // R8: the primary gate opens only once the secondary gate is shut
  p_pri_opens_after_sec_r8: assert property (@(negedge clk_pri) disable iff (!rst_n)
    $rose(gate_pri) |-> !gate_sec);
endmodule

// File: rtl/clksw_status.sv
module clksw_status #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_sec,
  input  logic rst_n,
  input  logic gate_pri,
  output logic on_primary,
  output logic switch_done
);
  logic gate_pri_s;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_gate (
    .clk(clk_sec), .rst_n(rst_n), .d(gate_pri), .q(gate_pri_s));

  always_ff @(posedge clk_sec or negedge rst_n) begin
    if (!rst_n) begin
      on_primary  <= 1'b0;
      switch_done <= 1'b0;
    end else begin
      on_primary  <= gate_pri_s;
      switch_done <= gate_pri_s & ~on_primary;
    end
  end

  // R9: the done pulse coincides with the status and lasts one cycle
  p_done_with_status_r9: assert property (@(posedge clk_sec) disable iff (!rst_n)
    switch_done |-> on_primary);
  p_done_single_r9: assert property (@(posedge clk_sec) disable iff (!rst_n)
    switch_done |=> !switch_done);
  // R11: dropping back to secondary raises no done pulse
  p_no_done_on_exit_r11: assert property (@(posedge clk_sec) disable iff (!rst_n)
    $fell(on_primary) |-> !switch_done);
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
  import clksw_pkg::*;
#(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned PRI_HZ      = 8_000_000,
  parameter int unsigned PLL_LOCK_US = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_sec,
  input  logic clk_pri,
  input  logic rst_n,
  input  logic sel_pri,
  input  logic mode_ext,
  input  logic pll_on,
  output logic sys_clk,
  output logic pri_osc_en,
  output logic pri_ready,
  output logic on_primary,
  output logic switch_done
);
  localparam int unsigned PLL_CYC = pll_cycles(PRI_HZ, PLL_LOCK_US);

  logic req_s;
  logic gate_pri, gate_sec;

  always_ff @(posedge clk_sec or negedge rst_n) begin
    if (!rst_n) pri_osc_en <= 1'b0;
    else        pri_osc_en <= sel_pri;
  end

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_req (
    .clk(clk_pri), .rst_n(rst_n), .d(sel_pri), .q(req_s));

  clksw_wait_seq #(.OST_CYCLES(OST_CYCLES), .PLL_CYCLES(PLL_CYC)) u_wait (
    .clk_pri(clk_pri), .rst_n(rst_n), .req_s(req_s),
    .mode_ext(mode_ext), .pll_on(pll_on), .ready(pri_ready));

  clksw_gmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .rst_n(rst_n), .go_pri(pri_ready),
    .sys_clk(sys_clk), .gate_pri(gate_pri), .gate_sec(gate_sec));

  clksw_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk_sec(clk_sec), .rst_n(rst_n), .gate_pri(gate_pri),
    .on_primary(on_primary), .switch_done(switch_done));

  // R2: the oscillator enable tracks the select bit one secondary edge later
  p_osc_en_r2: assert property (@(posedge clk_sec) disable iff (!rst_n)
    sel_pri |=> pri_osc_en);
  // R9: status never claims primary while the primary gate is shut
  p_status_after_gate_r9: assert property (@(posedge clk_sec) disable iff (!rst_n)
    $rose(on_primary) |-> gate_pri);
endmodule

// File: tb/sim_clk_switch_seq.sv
module sim_clk_switch_seq;
  localparam int TP_PRI = 10;
  localparam int TP_SEC = 34;
  localparam int OST    = 32;
  localparam int HZ     = 2_000_000;
  localparam int LUS    = 12;
  localparam int PLL    = (HZ / 1_000_000) * LUS;

  // {mode_ext, pll_on, expected latency}
  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b0, 32'(3 + OST)},
    {1'b0, 1'b1, 32'(3 + OST + PLL)},
    {1'b1, 1'b1, 32'(3 + PLL)},
    {1'b1, 1'b0, 32'(3)}
  };

  logic clk_sec = 1'b0, clk_pri = 1'b0, rst_n = 1'b0;
  logic sel_pri = 1'b0, mode_ext = 1'b0, pll_on = 1'b0;
  logic sys_clk, pri_osc_en, pri_ready, on_primary, switch_done;

  int nchk = 0, nfail = 0, done_cnt = 0, cyc = 0;
  bit finished = 0;

  always #(TP_PRI/2) clk_pri = ~clk_pri;
  always #(TP_SEC/2) clk_sec = ~clk_sec;

  clk_switch_seq #(.OST_CYCLES(OST), .PRI_HZ(HZ), .PLL_LOCK_US(LUS)) u0 (
    .clk_sec(clk_sec), .clk_pri(clk_pri), .rst_n(rst_n), .sel_pri(sel_pri),
    .mode_ext(mode_ext), .pll_on(pll_on), .sys_clk(sys_clk),
    .pri_osc_en(pri_osc_en), .pri_ready(pri_ready), .on_primary(on_primary),
    .switch_done(switch_done));

  always @(negedge clk_sec) if (switch_done) done_cnt++;

  always @(posedge clk_pri) begin
    cyc++;
    if (cyc == 60000 && !finished) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Sample sys_clk a little after each edge of the chosen source.
  task automatic follows(input bit pri, input string req);
    int bad = 0;
    for (int k = 0; k < 4; k++) begin
      if (pri) @(posedge clk_pri); else @(posedge clk_sec);
      #2; if (sys_clk !== 1'b1) bad++;
      if (pri) @(negedge clk_pri); else @(negedge clk_sec);
      #2; if (sys_clk !== 1'b0) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic request_and_measure(output int n);
    @(posedge clk_pri); #1 sel_pri = 1'b1;
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk_pri); #1; n++;
      if (pri_ready) break;
    end
  endtask

  task automatic wait_status(input bit want);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk_sec); #1;
      if (on_primary == want) break;
    end
  endtask

  task automatic release_to_sec(input string req);
    int d0;
    d0 = done_cnt;
    @(posedge clk_pri); #1 sel_pri = 1'b0;
    wait_status(1'b0);
    chk(on_primary == 1'b0, req, on_primary, 0);
    follows(1'b0, req);
    chk(done_cnt == d0, req, done_cnt - d0, 0);
  endtask

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";
      1: return "R4 R7";
      2: return "R5 R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int n, d0;
    repeat (4) @(posedge clk_sec);
    #3;
    // R1 reset state
    chk(pri_ready == 0 && on_primary == 0 && switch_done == 0 && pri_osc_en == 0,
        "R1", {pri_ready, on_primary, switch_done, pri_osc_en}, 0);
    follows(1'b0, "R1");
    @(negedge clk_sec); rst_n = 1'b1;
    repeat (3) @(posedge clk_sec);

    for (int i = 0; i < 4; i++) begin
      mode_ext = VEC[i][33];
      pll_on   = VEC[i][32];
      repeat (2) @(posedge clk_sec);
      d0 = done_cnt;
      request_and_measure(n);
      chk(n == int'(VEC[i][31:0]), vtag(i), n, int'(VEC[i][31:0]));
      chk(on_primary == 1'b0, "R9", on_primary, 0);
      wait_status(1'b1);
      chk(on_primary == 1'b1, "R9", on_primary, 1);
      follows(1'b1, "R8");
      chk(done_cnt - d0 == 1, "R9", done_cnt - d0, 1);
      chk(pri_osc_en == 1'b1, "R2", pri_osc_en, 1);
      release_to_sec("R11");
      chk(pri_osc_en == 1'b0, "R2", pri_osc_en, 0);
    end

    // R10: abort during the start-up count, then a full re-request
    mode_ext = 1'b0; pll_on = 1'b1;
    repeat (2) @(posedge clk_sec);
    d0 = done_cnt;
    @(posedge clk_pri); #1 sel_pri = 1'b1;
    repeat (3 + OST - 4) @(posedge clk_pri);
    #1 sel_pri = 1'b0;
    repeat (30) @(negedge clk_sec);
    #1;
    chk(pri_ready == 0 && on_primary == 0, "R10", {pri_ready, on_primary}, 0);
    follows(1'b0, "R10");
    chk(done_cnt == d0, "R10", done_cnt - d0, 0);
    request_and_measure(n);
    chk(n == 3 + OST + PLL, "R10", n, 3 + OST + PLL);
    wait_status(1'b1);
    chk(on_primary == 1'b1, "R10", on_primary, 1);
    release_to_sec("R11");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule